// File: doc/BRIEF.md
# Redundant Reference Switchover Controller

This block decides which of two redundant reference clocks, primary or secondary, feeds a timing PLL. It watches loss-of-signal flags for both references and the PLL holdover flag. It drives a reference-select output, a PLL operating-mode output and a loop-filter bandwidth output. All of these outputs follow control fields that software sets through a small byte-wide register port. Every write carries a bit mask, so software can update one field and leave the rest of the register alone.

In manual operation, the reference is the one that software selected. With automatic switching enabled, the block moves to the other reference when the trigger fires. The trigger is either a loss of signal on the reference now in use, or the PLL entering holdover, as software chooses. The block never moves onto a reference that is itself flagged lost. A software write to the manual select always takes precedence. All status inputs are expected to be synchronous to `clk` already.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset, `ref_sel` is 0 (primary), `pll_mode` is 00, `filter_narrow` is 0, and registers 0 and 1 both read 0x00.
- R2: Register 1 bit 0 is the manual select (0 primary, 1 secondary). A write that sets it takes effect on `ref_sel` at the next clock edge.
- R3: Register 1 bit 3 reads the reference in use (0 primary, 1 secondary). Writes to that bit are ignored.
- R4: While register 0 bit 7 (automatic switching enable) is 0, `ref_sel` equals the manual select whatever the status inputs do.
- R5: With bit 7 = 1 and register 0 bit 6 = 0, a loss of signal on the active reference while the other reference is healthy toggles `ref_sel` at the next clock edge.
- R6: With bit 7 = 1 and bit 6 = 1, a rising `pll_holdover` (low the cycle before, high now) toggles `ref_sel` at the next edge. A holdover flag that stays high causes no further switch.
- R7: An automatic switch never happens while the other reference's loss flag is high.
- R8: Register 0 bits 5:4 drive `pll_mode`: 00 normal, 01 holdover, 10 free-run. The reserved code 11 reads back as written but drives 00.
- R9: Register 0 bit 2 drives `filter_narrow`: 1 selects the 6 Hz filter, 0 selects the 12 Hz filter.
- R10: A write changes only the bits set in `reg_wmask`. Unimplemented bits read 0, and address 3 reads 0x00.
- R11: Register 2 is read-only status: bit 0 `pri_los`, bit 1 `sec_los`, bit 2 `pll_holdover`, bit 3 `pll_unlock`, and 0 above.
- R12: A manual-select write in the same cycle as an automatic trigger wins. `ref_sel` takes the written value.

Register addresses: 0 for control, 1 for reference select, 2 for status. The read port is combinational on `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_wmask | input | 8 | Per-bit write enable |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pri_los | input | 1 | Primary reference loss of signal |
| sec_los | input | 1 | Secondary reference loss of signal |
| pll_holdover | input | 1 | PLL is in holdover |
| pll_unlock | input | 1 | PLL is out of lock |
| ref_sel | output | 1 | Reference in use: 0 primary, 1 secondary |
| pll_mode | output | 2 | PLL operating mode: 00 normal, 01 holdover, 10 free-run |
| filter_narrow | output | 1 | 1 selects the 6 Hz loop filter, 0 selects the 12 Hz filter |

## Verification
The properties check the following on every cycle:
- With automatic switching off, the reference follows the manual select.
- A manual write always lands on `ref_sel` one edge later.
- An automatic switch never lands on a lost reference.
- A loss-triggered switch happens whenever its conditions hold, and a steady holdover causes no repeat switch.
- The reserved mode drives normal, and the in-use flag in register 1 matches `ref_sel`.

Only the bench's scenarios can show three things:
- the masked field writes leave neighbouring bits intact;
- the reserved code reads back as written;
- the sequence of double loss followed by recovery ends on the healthy reference.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int STAT_W   = 4;

  localparam int ADDR_CTL = 0;
  localparam int ADDR_SEL = 1;
  localparam int ADDR_STA = 2;

  localparam int BIT_HWEN = 7;
  localparam int BIT_TRIG = 6;
  localparam int BIT_MODE = 4;
  localparam int BIT_FILT = 2;
  localparam int BIT_MAN  = 0;
  localparam int BIT_CUR  = 3;

  localparam logic [DATA_W-1:0] CTL_IMPL = 8'hF4;
  localparam logic [DATA_W-1:0] SEL_IMPL = 8'h01;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HOLD   = 2'b01,
    MODE_FREE   = 2'b10,
    MODE_RSVD   = 2'b11
  } pll_mode_e;

  function automatic logic [DATA_W-1:0] merge_bits(
      input logic [DATA_W-1:0] old_v,
      input logic [DATA_W-1:0] new_v,
      input logic [DATA_W-1:0] mask,
      input logic [DATA_W-1:0] impl);
    return ((old_v & ~mask) | (new_v & mask)) & impl;
  endfunction
endpackage

// File: rtl/refsw_regs.sv
module refsw_regs
  import refsw_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] wmask,
  input  logic          cur_ref,
  input  logic [SW-1:0] status,
  output logic [DW-1:0] rdata,
  output logic          hw_en,
  output logic          trig_hold,
  output logic [1:0]    mode_raw,
  output logic          filt,
  output logic          man_sel,
  output logic          man_wr,
  output logic          man_val
);
  localparam logic [AW-1:0] A_CTL = AW'(ADDR_CTL);
  localparam logic [AW-1:0] A_SEL = AW'(ADDR_SEL);
  localparam logic [AW-1:0] A_STA = AW'(ADDR_STA);

  logic [DW-1:0] ctl_q, ctl_d;
  logic [DW-1:0] sel_q, sel_d;
  logic          ctl_en, sel_en;

  always_comb begin
    ctl_en = wr && (addr == A_CTL);
    sel_en = wr && (addr == A_SEL);
    ctl_d  = merge_bits(ctl_q, wdata, wmask, CTL_IMPL);
    sel_d  = merge_bits(sel_q, wdata, wmask, SEL_IMPL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      sel_q <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  always_comb begin
    hw_en     = ctl_q[BIT_HWEN];
    trig_hold = ctl_q[BIT_TRIG];
    mode_raw  = ctl_q[BIT_MODE +: 2];
    filt      = ctl_q[BIT_FILT];
    man_sel   = sel_q[BIT_MAN];
    man_wr    = sel_en && wmask[BIT_MAN];
    man_val   = wdata[BIT_MAN];
  end

  always_comb begin
    case (addr)
      A_CTL:   rdata = ctl_q;
      A_SEL:   rdata = sel_q | (DW'(cur_ref) << BIT_CUR);
      A_STA:   rdata = DW'(status);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/refsw_trigger.sv
module refsw_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_hold,
  input  logic cur_ref,
  input  logic pri_los,
  input  logic sec_los,
  input  logic pll_holdover,
  output logic fire
);
  logic hold_q;
  logic act_los, alt_los, hold_rise, evt;

  always_comb begin
    act_los   = cur_ref ? sec_los : pri_los;
    alt_los   = cur_ref ? pri_los : sec_los;
    hold_rise = pll_holdover && !hold_q;
    evt       = trig_hold ? hold_rise : act_los;
    fire      = evt && !alt_los;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= pll_holdover;
  end
endmodule

// File: rtl/refsw_select.sv
module refsw_select (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic man_wr,
  input  logic man_val,
  input  logic man_sel,
  input  logic fire,
  output logic cur_ref
);
  logic cur_q, cur_d;

  always_comb begin
    if (man_wr)      cur_d = man_val;
    else if (!hw_en) cur_d = man_sel;
    else if (fire)   cur_d = !cur_q;
    else             cur_d = cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= 1'b0;
    else        cur_q <= cur_d;
  end

  assign cur_ref = cur_q;
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
  import refsw_pkg::*;
#(
  parameter int DW       = DATA_W,
  parameter int AW       = ADDR_W,
  parameter int RST_SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_wmask,
  output logic [DW-1:0] reg_rdata,
  input  logic          pri_los,
  input  logic          sec_los,
  input  logic          pll_holdover,
  input  logic          pll_unlock,
  output logic          ref_sel,
  output logic [1:0]    pll_mode,
  output logic          filter_narrow
);
  logic [RST_SYNC-1:0] rst_pipe;
  logic                rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_SYNC-2:0], 1'b1};
  end
  assign rst_int = rst_pipe[RST_SYNC-1];

  logic       hw_en, trig_hold, filt, man_sel, man_wr, man_val, fire, cur_ref;
  logic [1:0] mode_raw;

  refsw_regs #(.DW(DW), .AW(AW), .SW(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .wmask(reg_wmask), .cur_ref(cur_ref),
    .status({pll_unlock, pll_holdover, sec_los, pri_los}),
    .rdata(reg_rdata), .hw_en(hw_en), .trig_hold(trig_hold),
    .mode_raw(mode_raw), .filt(filt), .man_sel(man_sel),
    .man_wr(man_wr), .man_val(man_val)
  );

  refsw_trigger u_trig (
    .clk(clk), .rst_n(rst_int), .trig_hold(trig_hold), .cur_ref(cur_ref),
    .pri_los(pri_los), .sec_los(sec_los), .pll_holdover(pll_holdover),
    .fire(fire)
  );

  refsw_select u_sel (
    .clk(clk), .rst_n(rst_int), .hw_en(hw_en), .man_wr(man_wr),
    .man_val(man_val), .man_sel(man_sel), .fire(fire), .cur_ref(cur_ref)
  );

  always_comb begin
    ref_sel       = cur_ref;
    filter_narrow = filt;
    pll_mode      = (mode_raw == MODE_RSVD) ? MODE_NORMAL : mode_raw;
  end
endmodule

// File: rtl/refsw_ctrl_chk.sv
module refsw_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_wmask,
  input logic [7:0] reg_rdata,
  input logic       pri_los,
  input logic       sec_los,
  input logic       pll_holdover,
  input logic       ref_sel,
  input logic [1:0] pll_mode,
  input logic       hw_en,
  input logic       trig_hold,
  input logic [1:0] mode_raw,
  input logic       man_sel
);
  logic man_w;
  assign man_w = reg_wr && (reg_addr == 2'd1) && reg_wmask[0];

  p_manual_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    man_w |=> (ref_sel == $past(reg_wdata[0])));

  p_hw_off_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_en |=> (ref_sel == man_sel));

  p_no_switch_into_los_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !man_w && (ref_sel ? pri_los : sec_los)) |=> $stable(ref_sel));

  p_los_switch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && !trig_hold && !man_w && (ref_sel ? sec_los : pri_los) &&
     !(ref_sel ? pri_los : sec_los)) |=> !$stable(ref_sel));

  p_hold_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_en && trig_hold && !man_w && pll_holdover && $past(pll_holdover))
    |=> $stable(ref_sel));

  p_rsvd_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_raw == 2'b11) |-> (pll_mode == 2'b00));

  p_cur_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[3] == ref_sel));
endmodule

bind refsw_ctrl refsw_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_int), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
  .pri_los(pri_los), .sec_los(sec_los), .pll_holdover(pll_holdover),
  .ref_sel(ref_sel), .pll_mode(pll_mode), .hw_en(hw_en),
  .trig_hold(trig_hold), .mode_raw(mode_raw), .man_sel(man_sel)
);

// File: tb/tb_refsw_ctrl.sv
`timescale 1ns/1ps
module tb_refsw_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_wmask = '0;
  logic [7:0] reg_rdata;
  logic       pri_los = 1'b0, sec_los = 1'b0, pll_holdover = 1'b0, pll_unlock = 1'b0;
  logic       ref_sel, filter_narrow;
  logic [1:0] pll_mode;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  refsw_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
    .pri_los(pri_los), .sec_los(sec_los), .pll_holdover(pll_holdover),
    .pll_unlock(pll_unlock), .ref_sel(ref_sel), .pll_mode(pll_mode),
    .filter_narrow(filter_narrow)
  );

  // behavioural reference model
  int m_hw, m_trig, m_mode, m_filt, m_man, m_cur, m_hprev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hw = 0; m_trig = 0; m_mode = 0; m_filt = 0; m_man = 0; m_cur = 0; m_hprev = 0;
    end else begin
      int act, alt, evt, mw, nman;
      act  = m_cur ? sec_los : pri_los;
      alt  = m_cur ? pri_los : sec_los;
      evt  = m_trig ? (pll_holdover && !m_hprev) : act;
      mw   = reg_wr && reg_addr == 1 && reg_wmask[0];
      nman = mw ? reg_wdata[0] : m_man;
      if (mw)          m_cur = reg_wdata[0];
      else if (!m_hw)  m_cur = m_man;
      else if (evt && !alt) m_cur = 1 - m_cur;
      m_man = nman;
      if (reg_wr && reg_addr == 0) begin
        if (reg_wmask[7]) m_hw   = reg_wdata[7];
        if (reg_wmask[6]) m_trig = reg_wdata[6];
        if (reg_wmask[4]) m_mode = (m_mode & 2) | reg_wdata[4];
        if (reg_wmask[5]) m_mode = (m_mode & 1) | (reg_wdata[5] << 1);
        if (reg_wmask[2]) m_filt = reg_wdata[2];
      end
      m_hprev = pll_holdover;
    end
  end

  function automatic int exp_rdata();
    case (reg_addr)
      2'd0: return (m_hw << 7) | (m_trig << 6) | (m_mode << 4) | (m_filt << 2);
      2'd1: return (m_cur << 3) | m_man;
      2'd2: return (pll_unlock << 3) | (pll_holdover << 2) | (sec_los << 1) | pri_los;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) begin
      chk("R2/R4/R5/R6/R7/R12 ref_sel vs model", ref_sel, m_cur);
      chk("R8 pll_mode vs model", pll_mode, (m_mode == 3) ? 0 : m_mode);
      chk("R9 filter vs model", filter_narrow, m_filt);
      chk("R10/R11 rdata vs model", reg_rdata, exp_rdata());
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_wmask = m;
    tick();
    reg_wr = 0; reg_wmask = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic rd(input logic [1:0] a, string tag, int exp);
    reg_addr = a;
    #0.1;
    chk(tag, reg_rdata, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    chk("R1 ref_sel", ref_sel, 0);
    chk("R1 pll_mode", pll_mode, 0);
    chk("R1 filter", filter_narrow, 0);
    rd(0, "R1 ctl reads 0", 8'h00);
    rd(1, "R1 sel reads 0", 8'h00);

    // R4 manual mode ignores loss
    pri_los = 1; idle(3);
    chk("R4 no switch with auto off", ref_sel, 0);
    wr(1, 8'h01, 8'h01);
    chk("R2 manual select secondary", ref_sel, 1);
    pri_los = 0; idle(1);

    // R9/R10/R8 masked field writes
    wr(0, 8'hFF, 8'h04);
    chk("R9 filter 6Hz", filter_narrow, 1);
    rd(0, "R10 only filter bit written", 8'h04);
    wr(0, 8'h10, 8'h30);
    chk("R8 mode holdover", pll_mode, 1);
    chk("R10 filter kept", filter_narrow, 1);
    wr(0, 8'h20, 8'h30);
    chk("R8 mode freerun", pll_mode, 2);
    wr(0, 8'hFF, 8'h30);
    chk("R8 reserved drives normal", pll_mode, 0);
    rd(0, "R8 reserved reads back", 8'h34);
    wr(0, 8'h00, 8'h30);
    rd(3, "R10 unused address", 8'h00);

    // R3 in-use flag read-only
    wr(1, 8'h00, 8'h08);
    rd(1, "R3 write to flag ignored", 8'h09);

    // R5/R7 loss-triggered switching
    wr(1, 8'h00, 8'h01);
    chk("R2 manual back to primary", ref_sel, 0);
    wr(0, 8'h80, 8'hC0);
    pri_los = 1; tick();
    chk("R5 switch on primary loss", ref_sel, 1);
    sec_los = 1; idle(3);
    chk("R7 both lost stay", ref_sel, 1);
    pri_los = 0; tick();
    chk("R5 switch back to healthy primary", ref_sel, 0);
    sec_los = 0; idle(2);

    // R6 holdover-triggered switching
    wr(0, 8'hC0, 8'h40);
    pll_holdover = 1; tick();
    chk("R6 switch on holdover rise", ref_sel, 1);
    idle(3);
    chk("R6 steady holdover no repeat", ref_sel, 1);
    pll_holdover = 0; pri_los = 1; idle(1);
    pll_holdover = 1; tick();
    chk("R7 no switch to lost primary", ref_sel, 1);
    pll_holdover = 0; pri_los = 0; idle(2);

    // R12 manual beats trigger in same cycle
    pll_holdover = 1;
    wr(1, 8'h01, 8'h01);
    chk("R12 manual write wins", ref_sel, 1);
    pll_holdover = 0; idle(1);

    // R11 status register
    pri_los = 1; pll_unlock = 1;
    rd(2, "R11 status bits", 8'h09);
    pll_holdover = 1; sec_los = 1;
    rd(2, "R11 status all", 8'h0F);
    idle(2);
    pri_los = 0; sec_los = 0; pll_holdover = 0; pll_unlock = 0;

    // R4 auto off returns to manual choice
    wr(1, 8'h00, 8'h01);
    wr(0, 8'h00, 8'h80);
    idle(2);
    chk("R4 follows manual after disable", ref_sel, 0);
    idle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule